// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block derives the serial bit clock of a stereo audio link from a faster reference clock. The ratio is programmed as a 10-bit whole part and a 9-bit fraction counted in 1/512 steps. Each bit-clock half-period lasts either the whole part or the whole part plus one reference cycle. A 9-bit phase accumulator picks the longer length just often enough that the mean bit-clock frequency equals f_ref / (2 · (whole + frac/512)).

Software works out the two divisor fields from the sample rate and sample width. The target is a bit clock of 2 × width × rate, for widths of 16 or 24 bits and rates from about 5.5 kHz to 192 kHz. The block also produces single-cycle rise and fall markers for logic running on the reference clock. It produces a word-select output that marks the left and right channel slots. The output is held quiet while the divider is disabled, while the link is a slave (the far end supplies the clocks) and while the whole part is zero.

Top module: `bclk_frac_div`

## Requirements
- R1: Over any 512 consecutive half-periods after the first, the total length is exactly 512·whole_div + frac_div reference cycles.
- R2: Each half-period after the first lasts whole_div or whole_div+1 cycles. At the start of each half-period frac_div is added into a 9-bit phase register, and the half-period gets the extra cycle exactly when that addition carries out of bit 8.
- R3: whole_div is 10 bits and frac_div is 9 bits wide. The extreme setting whole_div=1023, frac_div=511 gives half-periods of 1023 or 1024 cycles, following R2.
- R4: While clk_en is 0 or slave_mode is 1, bclk, ws, bclk_rise and bclk_fall are 0 from the next clock edge on. The phase register restarts from zero when the divider runs again.
- R5: While whole_div is 0, all four outputs are held at 0.
- R6: A new whole_div or frac_div value takes effect only from the next half-period boundary. The half-period in progress keeps its length, and the phase register carries on from its current value.
- R7: ws toggles once every W bit-clock periods, in the same cycle as a bclk falling edge. W is 16 when word24 is 0 and 24 when word24 is 1. ws is 0 when the divider starts.
- R8: bclk_rise is 1 for exactly the first cycle in which bclk is 1, and bclk_fall is 1 for exactly the first cycle in which bclk is 0 after being 1. Neither is 1 at any other time.
- R9: While rst_n is 0, all outputs are 0.
- R10: After the divider is enabled, bclk starts low. The first rising edge appears whole_div+1 cycles after enable: one cycle to arm, then one plain half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| whole_div | input | 10 | Whole part of the half-period length, in reference cycles |
| frac_div | input | 9 | Fractional part of the half-period length, in 1/512 cycles |
| clk_en | input | 1 | Divider enable |
| slave_mode | input | 1 | 1 = far end supplies the clocks, so the outputs stay quiet |
| word24 | input | 1 | Slot width select: 0 = 16 bits, 1 = 24 bits |
| bclk | output | 1 | Bit clock level |
| bclk_rise | output | 1 | One-cycle marker of a bclk rising edge |
| bclk_fall | output | 1 | One-cycle marker of a bclk falling edge |
| ws | output | 1 | Word select (channel slot) |

## Verification
The assertions assume that every control and divisor input is synchronous to the reference clock. They also assume that an enable or mode change counts as the divider going idle, which clears the word-select state without a falling edge. The bench changes inputs only a fixed delay after a falling clock edge, so every rising edge sees stable values. It changes divisors in the middle of a half-period, just after a bclk edge has been seen, so the boundary in question is unambiguous. All divisor values stay within their field widths, and the expected half-period lengths come from the bench's own model of the phase register.

// File: rtl/bfd_pkg.sv
// Shared widths and types for the fractional bit-clock divider.
// Assumes: one reference clock domain, synchronous active-low reset.
package bfd_pkg;
    localparam int BFD_INT_W  = 10;  // whole-part width
    localparam int BFD_FRAC_W = 9;   // fractional width (1/512 steps)
    localparam int BFD_WORD_A = 16;  // narrow slot width
    localparam int BFD_WORD_B = 24;  // wide slot width

    // Bit-clock level with its edge markers.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } bclk_state_t;
endpackage

// File: rtl/bfd_phase_acc.sv
// Half-period timer with fractional phase accumulation.
// Counts reference cycles in the current half-period and flags its last
// cycle. At each boundary it adds the fraction into the phase register and
// loads the next length (whole part, plus one on carry-out). While not
// running it keeps loading the inputs, so the first half-period is exact.
// Assumes: whole_div is nonzero whenever go is high.
module bfd_phase_acc
    import bfd_pkg::*;
#(
    parameter int INT_W  = BFD_INT_W,
    parameter int FRAC_W = BFD_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [INT_W-1:0]  whole_div,
    input  logic [FRAC_W-1:0] frac_div,
    output logic              half_end
);
    localparam int LEN_W = INT_W + 1;

    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_q;
    logic [FRAC_W-1:0] phase_q;
    logic [FRAC_W:0]   sum;
    logic              carry;

    assign sum      = {1'b0, phase_q} + {1'b0, frac_div};
    assign carry    = sum[FRAC_W];
    assign half_end = go && (cnt_q == (len_q - 1'b1));

    // Purpose: advance the cycle count, reload the length and phase at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            len_q   <= '0;
            phase_q <= '0;
        end else if (!go) begin
            cnt_q   <= '0;
            len_q   <= {1'b0, whole_div};
            phase_q <= frac_div;
        end else if (half_end) begin
            cnt_q   <= '0;
            len_q   <= {1'b0, whole_div} + LEN_W'(carry);
            phase_q <= sum[FRAC_W-1:0];
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bfd_edge_gen.sv
// Bit-clock level and edge markers.
// Toggles the level at every half-period boundary and raises a one-cycle
// rise or fall marker in the first cycle of the new level.
// Assumes: half_end is only high while go is high.
module bfd_edge_gen
    import bfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        half_end,
    output bclk_state_t st
);
    // Purpose: hold the level low when idle, toggle it and mark the edge at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (!go) begin
            st <= '0;
        end else if (half_end) begin
            st.level <= ~st.level;
            st.rise  <= ~st.level;
            st.fall  <= st.level;
        end else begin
            st.rise  <= 1'b0;
            st.fall  <= 1'b0;
        end
    end
endmodule

// File: rtl/bfd_word_sel.sv
// Word-select generator.
// Counts bit-clock falling edges and toggles the word select after a full
// slot of WORD_A or WORD_B bits, in the same cycle as the falling edge.
// Assumes: fall_tick is high for one cycle per bit-clock falling edge.
module bfd_word_sel
    import bfd_pkg::*;
#(
    parameter int WORD_A = BFD_WORD_A,
    parameter int WORD_B = BFD_WORD_B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic fall_tick,
    input  logic word24,
    output logic ws
);
    localparam int CW = $clog2(WORD_B);
    localparam logic [CW-1:0] LAST_A = CW'(WORD_A - 1);
    localparam logic [CW-1:0] LAST_B = CW'(WORD_B - 1);

    logic [CW-1:0] bit_q;
    logic [CW-1:0] last;

    assign last = word24 ? LAST_B : LAST_A;

    // Purpose: count falling edges within the slot and flip ws at the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            ws    <= 1'b0;
        end else if (!go) begin
            bit_q <= '0;
            ws    <= 1'b0;
        end else if (fall_tick) begin
            if (bit_q >= last) begin
                bit_q <= '0;
                ws    <= ~ws;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bclk_frac_div.sv
// Fractional audio bit-clock divider, top level.
// Decides whether the divider runs (enabled, master, nonzero whole part),
// arms for one cycle so the first length is loaded from settled inputs,
// then drives the half-period timer, the edge generator and the word select.
// Assumes: all inputs are synchronous to clk.
module bclk_frac_div
    import bfd_pkg::*;
#(
    parameter int INT_W  = BFD_INT_W,
    parameter int FRAC_W = BFD_FRAC_W,
    parameter int WORD_A = BFD_WORD_A,
    parameter int WORD_B = BFD_WORD_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  whole_div,
    input  logic [FRAC_W-1:0] frac_div,
    input  logic              clk_en,
    input  logic              slave_mode,
    input  logic              word24,
    output logic              bclk,
    output logic              bclk_rise,
    output logic              bclk_fall,
    output logic              ws
);
    logic        run_in;
    logic        armed_q;
    logic        go;
    logic        half_end;
    logic        fall_tick;
    bclk_state_t st;

    assign run_in    = clk_en && !slave_mode && (whole_div != '0);
    assign go        = run_in && armed_q;
    assign fall_tick = half_end && st.level;

    // Purpose: arm the divider one cycle after the run conditions first hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= run_in;
        end
    end

    bfd_phase_acc #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .whole_div (whole_div),
        .frac_div  (frac_div),
        .half_end  (half_end)
    );

    bfd_edge_gen u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .half_end (half_end),
        .st       (st)
    );

    bfd_word_sel #(
        .WORD_A (WORD_A),
        .WORD_B (WORD_B)
    ) u_ws (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .fall_tick (fall_tick),
        .word24    (word24),
        .ws        (ws)
    );

    assign bclk      = st.level;
    assign bclk_rise = st.rise;
    assign bclk_fall = st.fall;
endmodule

// File: rtl/bfd_checker.sv
// Property checker for bclk_frac_div, attached by bind.
// Assumes: inputs synchronous to clk; idle clears ws without a falling edge.
module bfd_checker #(
    parameter int INT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [INT_W-1:0] whole_div,
    input logic             clk_en,
    input logic             slave_mode,
    input logic             bclk,
    input logic             bclk_rise,
    input logic             bclk_fall,
    input logic             ws
);
    localparam int GAP_W = INT_W + 2;

    logic             run;
    logic             bclk_d;
    logic [GAP_W-1:0] gap_q;

    assign run = clk_en && !slave_mode && (whole_div != '0);

    // Purpose: count cycles since the last bclk change while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || (bclk != bclk_d)) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
        bclk_d <= rst_n ? bclk : 1'b0;
    end

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en || slave_mode) |=> (!bclk && !ws && !bclk_rise && !bclk_fall));

    p_zero_div_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (whole_div == '0) |=> (!bclk && !ws));

    p_rise_marks_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |-> (bclk && !$past(bclk)));

    p_fall_marks_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |-> (!bclk && $past(bclk)));

    p_edge_has_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && !$past(bclk)) |-> bclk_rise);

    p_ws_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ws != $past(ws)) && $past(run)) |-> bclk_fall);

    p_half_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_W'(1 << INT_W));
endmodule

bind bclk_frac_div bfd_checker #(.INT_W(INT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .whole_div  (whole_div),
    .clk_en     (clk_en),
    .slave_mode (slave_mode),
    .bclk       (bclk),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .ws         (ws)
);

// File: tb/bclk_frac_div_test.sv
`timescale 1ns/1ps
module bclk_frac_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] whole_div = '0;
    logic [8:0] frac_div = '0;
    logic       clk_en = 1'b0;
    logic       slave_mode = 1'b0;
    logic       word24 = 1'b0;
    logic       bclk, bclk_rise, bclk_fall, ws;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_q[$];
    int    meas_q[$];
    bit    mon_on = 1'b0;
    int    cyc, falls, toggles, ws_flips, exp_w, mon_e;
    logic  prev_b, prev_ws;
    string cur_req = "R2";
    bit    done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bclk_frac_div uut (
        .clk(clk), .rst_n(rst_n), .whole_div(whole_div), .frac_div(frac_div),
        .clk_en(clk_en), .slave_mode(slave_mode), .word24(word24),
        .bclk(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .ws(ws)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pop expected half-period lengths and compare with measured ones.
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (bclk !== prev_b) begin
                toggles++;
                check((bclk_rise === bclk) && (bclk_fall === prev_b), "R8 edge marker",
                      int'({bclk_rise, bclk_fall}), int'({bclk, prev_b}));
                if (exp_q.size() > 0) begin
                    mon_e = exp_q.pop_front();
                    meas_q.push_back(cyc);
                    check(cyc == mon_e, cur_req, cyc, mon_e);
                end
                if (!bclk) falls++;
                cyc = 0;
            end else if (bclk_rise || bclk_fall) begin
                check(1'b0, "R8 stray marker", int'({bclk_rise, bclk_fall}), 0);
            end
            if (ws !== prev_ws) begin
                ws_flips++;
                check(prev_b && !bclk && (falls == exp_w), "R7 ws slot", falls, exp_w);
                falls = 0;
            end
            prev_b  = bclk;
            prev_ws = ws;
        end
    end

    // Driver model: expected half lengths, config A up to half chg, then B.
    task automatic push_model(input int na, input int fa, input int nb, input int fb,
                              input int chg, input int total);
        int phase;
        phase = fa;
        exp_q.delete();
        exp_q.push_back(na + 1);
        for (int k = 1; k < total; k++) begin
            int n, f, s;
            n = (k <= chg) ? na : nb;
            f = (k <= chg) ? fa : fb;
            s = phase + f;
            phase = s % 512;
            exp_q.push_back(n + ((s >= 512) ? 1 : 0));
        end
    endtask

    task automatic start_run(input int n, input int f, input bit w24);
        @(negedge clk); #2;
        whole_div = 10'(n); frac_div = 9'(f); word24 = w24; slave_mode = 1'b0;
        exp_w = w24 ? 24 : 16;
        cyc = 0; falls = 0; toggles = 0; ws_flips = 0;
        prev_b = 1'b0; prev_ws = 1'b0;
        meas_q.delete();
        mon_on = 1'b1;
        clk_en = 1'b1;
    endtask

    task automatic drain_and_stop();
        while (exp_q.size() != 0) begin @(negedge clk); #1; end
        #1;
        mon_on = 1'b0;
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet_check(input string req, input int cycles);
        bit ok;
        int seen;
        ok = 1'b1; seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (bclk || ws || bclk_rise || bclk_fall) begin ok = 1'b0; seen = 1; end
        end
        check(ok, req, seen, 0);
    endtask

    initial begin
        int total;
        // R9: outputs during reset
        repeat (3) @(negedge clk);
        check(!bclk && !ws && !bclk_rise && !bclk_fall, "R9 reset state",
              int'({bclk, ws, bclk_rise, bclk_fall}), 0);
        #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R10: plain integer divide
        cur_req = "R2 half length N=3 F=0";
        push_model(3, 0, 3, 0, 100, 10);
        start_run(3, 0, 1'b0);
        drain_and_stop();
        check(meas_q[0] == 4, "R10 first half", meas_q[0], 4);

        // R2: fast ratio with large fraction
        cur_req = "R2 half length N=1 F=511";
        push_model(1, 511, 1, 511, 100, 20);
        start_run(1, 511, 1'b0);
        drain_and_stop();

        // R1: average over 512 half-periods
        cur_req = "R2 half length N=2 F=301";
        push_model(2, 301, 2, 301, 1000, 513);
        start_run(2, 301, 1'b0);
        drain_and_stop();
        total = 0;
        for (int k = 1; k < 513; k++) total += meas_q[k];
        check(total == 512 * 2 + 301, "R1 average length", total, 512 * 2 + 301);

        // R6: divisor change mid half-period
        cur_req = "R6 boundary update";
        push_model(3, 200, 5, 300, 3, 12);
        start_run(3, 200, 1'b0);
        while (toggles < 3) begin @(negedge clk); #1; end
        #1;
        whole_div = 10'd5; frac_div = 9'd300;
        drain_and_stop();

        // R3: extreme field values
        cur_req = "R3 max divisors";
        push_model(1023, 511, 1023, 511, 100, 4);
        start_run(1023, 511, 1'b0);
        drain_and_stop();

        // R7: 16-bit slots
        cur_req = "R2 half length W16";
        push_model(2, 0, 2, 0, 1000, 70);
        start_run(2, 0, 1'b0);
        while (exp_q.size() != 0) begin @(negedge clk); #1; end
        check(ws_flips == 2, "R7 ws flips W16", ws_flips, 2);
        drain_and_stop();

        // R7: 24-bit slots
        cur_req = "R2 half length W24";
        push_model(2, 0, 2, 0, 1000, 100);
        start_run(2, 0, 1'b1);
        while (exp_q.size() != 0) begin @(negedge clk); #1; end
        check(ws_flips == 2, "R7 ws flips W24", ws_flips, 2);
        drain_and_stop();

        // R4: slave mode, enabled
        @(negedge clk); #2;
        whole_div = 10'd4; frac_div = 9'd0; slave_mode = 1'b1; clk_en = 1'b1;
        quiet_check("R4 slave quiet", 60);
        // R4: disabled
        #2 slave_mode = 1'b0; clk_en = 1'b0;
        quiet_check("R4 disabled quiet", 60);
        // R5: zero whole part
        #2 whole_div = 10'd0; clk_en = 1'b1;
        quiet_check("R5 zero divisor quiet", 60);
        #2 clk_en = 1'b0;

        // R4: abort while bclk high
        @(negedge clk); #2;
        whole_div = 10'd6; clk_en = 1'b1;
        while (bclk !== 1'b1) begin @(negedge clk); #1; end
        #1 slave_mode = 1'b1;
        @(negedge clk);
        check(!bclk && !ws, "R4 abort to low", int'({bclk, ws}), 0);
        #2 slave_mode = 1'b0; clk_en = 1'b0;
        repeat (2) @(negedge clk);

        // R4: phase restarts after abort
        cur_req = "R4 restart half length";
        push_model(1, 511, 1, 511, 100, 8);
        start_run(1, 511, 1'b0);
        drain_and_stop();

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule